// File: doc/BRIEF.md
# Single-Pin PWM Audio DAC with Selectable Pulse Spreading

This block converts unsigned audio samples into a one-bit pulse stream for a single output pin. The pin feeds an external RC low-pass filter, and the filter output drives a speaker. A free-running reference counter steps through one PWM period of 2^N clocks. On each clock the held sample is compared with a permuted copy of that count. The output is high while the sample is strictly larger than the permuted count.

Before the comparison, a configuration value selects how many of the counter's top bits are mirrored among themselves. With no bits mirrored, each period has one high run followed by one low run. This gives the fewest edges and the least sensitivity to unequal rise and fall times. With every bit mirrored, the high clocks are spread as evenly as possible across the period. This gives the most edges and the simplest job for the filter. The number of high clocks per period is the same for every setting.

A load strobe places a new sample and a new setting into a holding stage. Both take effect together at the next period boundary, so a period that has already started always completes with the values it began with.

Top module: `pwmdac_top`

## Requirements
- R1: While reset is asserted, and through the first full period after reset is released, the output is 0. Reset clears the counter, the holding stage, the active stage and the output.
- R2: The reference counter advances by one on every clock and wraps from 2^N-1 to 0. Each wrap ends one PWM period. With an active sample k, the output is high for exactly k clocks in every period.
- R3: An active sample of 0 keeps the output at constant 0. An active sample of 2^N-1 keeps the output high on all clocks of a period except one.
- R4: When the setting is 0, the count is compared unpermuted. Each period starts with k high clocks followed by 2^N-k low clocks, so there is one falling edge inside the period.
- R5: When the setting is N and the sample is 2^(N-1), the output alternates on every clock, giving 2^N-1 edges inside the period.
- R6: For a setting r, the compared value is the count with bits N-1 down to N-r placed in reversed order. Bit N-1-j of the count moves to position N-r+j, and bits below N-r are unchanged. The output is sample > compared value.
- R7: When the load strobe is high, the sample and setting inputs are captured into the holding stage. They become active on the clock where the counter wraps, and not before. A strobe in the last clock of a period applies to the very next period.
- R8: A setting larger than N is treated as N.
- R9: The output is registered. The pin level in a clock reflects the comparison made with the count of the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | N | Unsigned audio sample |
| sampleLoad | input | 1 | Captures sampleIn and revSel into the holding stage |
| revSel | input | $clog2(N+1) | Number of top counter bits to mirror (values above N clamp to N) |
| pwmOut | output | 1 | Registered pulse stream to the RC filter |

## Verification
The hardest case to reach is a load strobe that lands exactly on the wrap clock, or a few clocks before it. In that case the holding stage and the active stage change almost together. The bench places strobes at chosen offsets inside a period, including the last clock. A cycle-accurate behavioural model then shows whether the new values leaked into the running period or missed the next one. Settings above N are driven directly so that the clamp is observed through the edge count.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic periodEnd;  // counter is at its last value of the period
    logic takeInput;  // load strobe qualified for capture
  } pwmStrobes_t;
endpackage

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleLoad,
  output logic [N-1:0] refCount,
  output pwmStrobes_t  strobes
);
  localparam logic [N-1:0] CountMax = {N{1'b1}};

  logic [N-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    strobes.periodEnd = (cnt == CountMax);
    strobes.takeInput = sampleLoad;
    refCount          = cnt;
  end

  // R2: counter wraps at the end of the period
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == CountMax) |=> (cnt == '0));
  // R2: counter steps by one inside the period
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != CountMax) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwmdac_dpath.sv
module pwmdac_dpath
  import pwmdac_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  pwmStrobes_t   strobes,
  input  logic [N-1:0]  refCount,
  input  logic [N-1:0]  sampleIn,
  input  logic [RW-1:0] revSel,
  output logic          pwmOut
);
  localparam logic [RW-1:0] RevMax = RW'(N);

  logic [N-1:0]  pendSample, actSample;
  logic [RW-1:0] pendRev, actRev;
  logic [RW-1:0] revClamped;
  logic [N-1:0]  nextSample;
  logic [RW-1:0] nextRev;
  logic [N-1:0]  permAll [0:N];
  logic [N-1:0]  permCount;
  logic          cmpHigh;

  // R8: settings beyond N clamp to N
  assign revClamped = (revSel > RevMax) ? RevMax : revSel;

  // Holding stage value as seen by the wrap edge (strobe bypass)
  assign nextSample = strobes.takeInput ? sampleIn   : pendSample;
  assign nextRev    = strobes.takeInput ? revClamped : pendRev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendSample <= '0;
      pendRev    <= '0;
    end else if (strobes.takeInput) begin
      pendSample <= sampleIn;
      pendRev    <= revClamped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actSample <= '0;
      actRev    <= '0;
    end else if (strobes.periodEnd) begin
      actSample <= nextSample;
      actRev    <= nextRev;
    end
  end

  // One permutation per possible setting
  for (genvar r = 0; r <= N; r++) begin : g_perm
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= N - r) begin : g_mirror
        assign permAll[r][i] = refCount[2*N-1-r-i];
      end else begin : g_pass
        assign permAll[r][i] = refCount[i];
      end
    end
  end

  assign permCount = permAll[actRev];
  assign cmpHigh   = (actSample > permCount);

  always_ff @(posedge clk) begin
    if (rst) pwmOut <= 1'b0;
    else     pwmOut <= cmpHigh;
  end

  // R7: active values hold except on the wrap clock
  p_hold_mid_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.periodEnd |=> ($stable(actSample) && $stable(actRev)));
  // R8: active setting never exceeds N
  p_rev_range_r8: assert property (@(posedge clk) disable iff (rst)
    actRev <= RevMax);
  // R3: zero sample gives a low pin on the next clock
  p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
    (actSample == '0) |=> !pwmOut);
  // R6: unpermuted count of zero with nonzero sample drives high
  p_first_high_r6: assert property (@(posedge clk) disable iff (rst)
    (refCount == '0 && actSample != '0) |=> pwmOut);
endmodule

// File: rtl/pwmdac_top.sv
module pwmdac_top #(
  parameter int N  = 8,
  parameter int RW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  sampleIn,
  input  logic          sampleLoad,
  input  logic [RW-1:0] revSel,
  output logic          pwmOut
);
  import pwmdac_pkg::*;

  pwmStrobes_t  strobes;
  logic [N-1:0] refCount;

  pwmdac_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleLoad (sampleLoad),
    .refCount   (refCount),
    .strobes    (strobes)
  );

  pwmdac_dpath #(.N(N), .RW(RW)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .refCount (refCount),
    .sampleIn (sampleIn),
    .revSel   (revSel),
    .pwmOut   (pwmOut)
  );
endmodule

// File: tb/sim_pwmdac_top.sv
`timescale 1ns/1ps
module sim_pwmdac_top;
  localparam int N   = 8;
  localparam int RW  = $clog2(N + 1);
  localparam int PER = 1 << N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  sampleIn = '0;
  logic          sampleLoad = 1'b0;
  logic [RW-1:0] revSel = '0;
  logic          pwmOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state
  int mCnt = 0, mPendS = 0, mPendR = 0, mActS = 0, mActR = 0, mOut = 0;

  always #2.5 clk = ~clk;

  pwmdac_top #(.N(N)) u0 (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleLoad(sampleLoad),
    .revSel(revSel), .pwmOut(pwmOut)
  );

  function automatic int permute(int c, int r);
    int low, top, rv;
    low = c % (1 << (N - r));
    top = c >> (N - r);
    rv  = 0;
    for (int j = 0; j < r; j++) rv = (rv << 1) | ((top >> j) & 1);
    return (rv << (N - r)) | low;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mPendS = 0; mPendR = 0; mActS = 0; mActR = 0; mOut = 0;
    end else begin
      int nOut, rr;
      nOut = (mActS > permute(mCnt, mActR)) ? 1 : 0;
      if (sampleLoad) begin
        rr = (int'(revSel) > N) ? N : int'(revSel);
        mPendS = int'(sampleIn);
        mPendR = rr;
      end
      if (mCnt == PER - 1) begin
        mActS = mPendS; mActR = mPendR;
      end
      mCnt = (mCnt + 1) % PER;
      mOut = nOut;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R6, R9)
  always @(negedge clk) begin
    if (!rst && !done) check("R6/R9 per-clock", int'(pwmOut), mOut);
  end

  task automatic waitCnt(int v);
    do @(negedge clk); while (mCnt != v);
  endtask

  task automatic load(int s, int r);
    sampleIn = N'(s); revSel = RW'(r); sampleLoad = 1'b1;
    @(negedge clk);
    sampleLoad = 1'b0;
  endtask

  // Measure one output-aligned period: high count and in-period edges
  task automatic measure(output int highs, output int edges);
    int prev;
    waitCnt(1);
    highs = 0; edges = 0; prev = -1;
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      highs += int'(pwmOut);
      if (prev >= 0 && prev != int'(pwmOut)) edges++;
      prev = int'(pwmOut);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int h, e;
    repeat (4) @(negedge clk);
    check("R1 reset output", int'(pwmOut), 0);
    rst = 1'b0;
    measure(h, e);
    check("R1 first period highs", h, 0);

    // R4: setting 0, one run per period
    waitCnt(5); load(100, 0);
    measure(h, e);
    check("R2 highs k=100", h, 100);
    check("R4 edges r=0", e, 1);

    // R5: full mirror, half scale
    waitCnt(5); load(PER / 2, N);
    measure(h, e);
    check("R2 highs k=128", h, PER / 2);
    check("R5 edges r=N", e, PER - 1);

    // R6: partial mirror
    waitCnt(5); load(77, 3);
    measure(h, e);
    check("R6 highs r=3", h, 77);

    // R3: full scale and zero
    waitCnt(5); load(PER - 1, 5);
    measure(h, e);
    check("R3 highs max", h, PER - 1);
    waitCnt(5); load(0, 2);
    measure(h, e);
    check("R3 highs zero", h, 0);
    check("R3 edges zero", e, 0);

    // R8: out-of-range setting clamps to N
    waitCnt(5); load(PER / 2, (1 << RW) - 1);
    measure(h, e);
    check("R8 clamp edges", e, PER - 1);

    // R7: mid-period strobe does not disturb running period
    waitCnt(5); load(40, 0);
    measure(h, e);
    waitCnt(100); load(200, 0);
    waitCnt(PER - 1);
    check("R7 pin before wrap", int'(pwmOut), 0);
    measure(h, e);
    check("R7 new sample next period", h, 200);

    // R7: strobe on the last clock of a period applies next period
    waitCnt(PER - 1); load(10, 0);
    measure(h, e);
    check("R7 last-clock strobe", h, 10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule